// File: doc/BRIEF.md
# Partitioned SIMD Adder With Guard Bits

This block is a 64-bit two-operand adder that can also split into independent narrower adders: one 64-bit lane, two 32-bit lanes, four 16-bit lanes or eight 8-bit lanes. A single extra bit is placed in each operand at every byte edge, which gives one unbroken 71-bit carry chain. The two bits placed at an edge decide what happens to the carry there. A pair of 1 and 0 passes the carry through. A pair of 0 and 0 stops it. A pair of 1 and 1 forces a carry into the lane above. No gate is placed in the carry path.

The packed result drops the sum bits at the edge positions. The carry out of each lane is recovered from the edge position that sits above it. Subtraction inverts the second operand and forces a carry into every lane, and the lane carries are then reported as borrows. An extend mode adds an external carry-in to every lane. For scalar work a size input selects a carry flag taken from the chain above bit 8, 16, 32 or 64. The result, the lane carries and the flag are registered once, so the latency is one clock.

Top module: `simd_guard_adder`

## Requirements
- R1: While `rst` is high at a rising clock edge, `sum_q`, `lane_carry_q` and `carry_flag_q` are all cleared to zero at that edge.
- R2: With `lane_mode` = 00 (one 64-bit lane), `sub_en` = 0 and `ext_en` = 0, `sum_q` equals `op_a + op_b` modulo 2^64. It appears one clock after the operands are presented.
- R3: `lane_mode` 01, 10 and 11 split the operands into 2x32, 4x16 and 8x8 lanes respectively, with lane 0 in the least significant bits. Each lane of `sum_q` is the sum of its own operand slices, and no carry crosses a lane edge.
- R4: `lane_carry_q[j]` holds the carry (or borrow) out of the lane whose most significant byte is byte j. Every bit of `lane_carry_q` that is not the top byte of a lane reads 0. In mode 00 only bit 7 is used.
- R5: `op_size` 00, 01, 10 and 11 make `carry_flag_q` the carry out of bits 7:0, 15:0, 31:0 and 63:0 of the scalar operation, including its carry-in. This flag is defined for `lane_mode` 00.
- R6: With `sub_en` = 1, every lane computes A minus B in its own width. The `lane_carry_q` bits and `carry_flag_q` report the borrow, which is 1 when the unsigned A slice is smaller than B plus the borrow-in.
- R7: With `ext_en` = 1 and `sub_en` = 0, `ext_in` is added as carry-in to every lane in every mode. With `ext_en` = 0, `ext_in` has no effect on any output.
- R8: With `sub_en` = 1, `ext_en` and `ext_in` have no effect: every lane subtracts with no borrow-in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_a | input | 64 | First operand |
| op_b | input | 64 | Second operand (subtrahend when subtracting) |
| lane_mode | input | 2 | 00 one lane, 01 2x32, 10 4x16, 11 8x8 |
| op_size | input | 2 | Scalar flag size: 00 byte, 01 word, 10 long, 11 64-bit |
| sub_en | input | 1 | Subtract instead of add |
| ext_en | input | 1 | Use ext_in as per-lane carry-in |
| ext_in | input | 1 | External carry-in value |
| sum_q | output | 64 | Registered packed result |
| lane_carry_q | output | 8 | Registered per-lane carry or borrow, indexed by byte |
| carry_flag_q | output | 1 | Registered size-selected scalar carry or borrow |

## Verification
An operand of all ones plus a value with 1 in each byte's low bit ripples a carry across every byte edge. The result therefore shows directly whether an edge passes, blocks or injects the carry in each mode. Operands that differ only at the 8, 16 and 32 bit points show whether the flag multiplexer picks the right position. Subtraction with A below B in some lanes and above it in others shows that borrows stay inside their lane. Extend with ext_in at both values, and with ext_en at both values, separates the forced-carry pattern from the blocked one. Random operands in all mode and size combinations are then compared with a model built from separate narrow additions.

// File: rtl/simd_add_pkg.sv
package simd_add_pkg;

    typedef enum logic [1:0] {
        MODE_FULL    = 2'b00,
        MODE_HALF    = 2'b01,
        MODE_QUARTER = 2'b10,
        MODE_BYTE    = 2'b11
    } lane_mode_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_WORD = 2'b01,
        SZ_LONG = 2'b10,
        SZ_QUAD = 2'b11
    } op_size_e;

    // Guard pair written as {bit in A, bit in B}
    typedef enum logic [1:0] {
        GUARD_BLOCK  = 2'b00,
        GUARD_PASS   = 2'b10,
        GUARD_INJECT = 2'b11
    } guard_e;

    typedef struct packed {
        lane_mode_e mode;
        logic       sub;
        logic       ext_en;
        logic       ext_in;
    } add_ctl_t;

    // Number of bytes per lane for a mode
    function automatic int unsigned lane_span(input lane_mode_e m, input int unsigned nbytes);
        return nbytes >> m;
    endfunction

    // True when byte edge k (between byte k-1 and k) is a lane edge
    function automatic logic edge_active(input int unsigned k, input int unsigned span);
        return ((k & (span - 1)) == 0);
    endfunction

    function automatic guard_e guard_for(input logic active, input add_ctl_t c);
        if (!active)      return GUARD_PASS;
        if (c.sub)        return GUARD_INJECT;
        if (c.ext_en && c.ext_in) return GUARD_INJECT;
        return GUARD_BLOCK;
    endfunction

    // Byte whose carry out forms the scalar flag
    function automatic int unsigned flag_byte(input op_size_e s, input int unsigned nbytes);
        int unsigned idx;
        idx = (1 << s) - 1;
        if (idx > nbytes - 1) idx = nbytes - 1;
        return idx;
    endfunction

endpackage

// File: rtl/guard_encoder.sv
module guard_encoder
    import simd_add_pkg::*;
#(
    parameter int LANE_W    = 8,
    parameter int NUM_BYTES = 8,
    localparam int DATA_W   = LANE_W * NUM_BYTES,
    localparam int CHAIN_W  = NUM_BYTES * (LANE_W + 1) - 1
) (
    input  logic [DATA_W-1:0]  a,
    input  logic [DATA_W-1:0]  b,
    input  add_ctl_t           ctl,
    output logic [CHAIN_W-1:0] wide_a,
    output logic [CHAIN_W-1:0] wide_b,
    output logic               cin
);
    logic [DATA_W-1:0] b_eff;
    int unsigned       span;

    assign b_eff = ctl.sub ? ~b : b;
    assign span  = lane_span(ctl.mode, NUM_BYTES);
    assign cin   = ctl.sub | (ctl.ext_en & ctl.ext_in);

    for (genvar k = 0; k < NUM_BYTES; k++) begin : g_byte
        localparam int BASE = k * (LANE_W + 1);
        assign wide_a[BASE +: LANE_W] = a[k*LANE_W +: LANE_W];
        assign wide_b[BASE +: LANE_W] = b_eff[k*LANE_W +: LANE_W];
        if (k > 0) begin : g_guard
            guard_e gp;
            assign gp = guard_for(edge_active(k, span), ctl);
            assign wide_a[BASE-1] = gp[1];
            assign wide_b[BASE-1] = gp[0];
        end
    end
endmodule

// File: rtl/carry_chain.sv
module carry_chain #(
    parameter int W = 71
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         cin,
    output logic [W-1:0] s,
    output logic         cout
);
    logic [W:0] total;

    assign total = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
    assign s     = total[W-1:0];
    assign cout  = total[W];
endmodule

// File: rtl/result_extract.sv
module result_extract
    import simd_add_pkg::*;
#(
    parameter int LANE_W    = 8,
    parameter int NUM_BYTES = 8,
    localparam int DATA_W   = LANE_W * NUM_BYTES,
    localparam int CHAIN_W  = NUM_BYTES * (LANE_W + 1) - 1
) (
    input  logic [CHAIN_W-1:0]   wide_a,
    input  logic [CHAIN_W-1:0]   wide_b,
    input  logic [CHAIN_W-1:0]   wide_s,
    input  logic                 cout,
    input  add_ctl_t             ctl,
    input  op_size_e             size,
    output logic [DATA_W-1:0]    sum,
    output logic [NUM_BYTES-1:0] lane_c,
    output logic                 flag
);
    logic [NUM_BYTES-1:0] raw_c;
    int unsigned          span;

    assign span = lane_span(ctl.mode, NUM_BYTES);

    for (genvar k = 0; k < NUM_BYTES; k++) begin : g_byte
        localparam int BASE = k * (LANE_W + 1);
        assign sum[k*LANE_W +: LANE_W] = wide_s[BASE +: LANE_W];
        if (k < NUM_BYTES - 1) begin : g_mid
            localparam int G = BASE + LANE_W;
            // carry entering the guard position is the byte's carry out
            assign raw_c[k] = wide_a[G] ^ wide_b[G] ^ wide_s[G];
        end else begin : g_top
            assign raw_c[k] = cout;
        end
        assign lane_c[k] = edge_active(k + 1, span) ? (raw_c[k] ^ ctl.sub) : 1'b0;
    end

    assign flag = raw_c[flag_byte(size, NUM_BYTES)] ^ ctl.sub;
endmodule

// File: rtl/simd_guard_adder.sv
module simd_guard_adder
    import simd_add_pkg::*;
#(
    parameter int LANE_W    = 8,
    parameter int NUM_BYTES = 8,
    localparam int DATA_W   = LANE_W * NUM_BYTES,
    localparam int CHAIN_W  = NUM_BYTES * (LANE_W + 1) - 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [DATA_W-1:0]    op_a,
    input  logic [DATA_W-1:0]    op_b,
    input  logic [1:0]           lane_mode,
    input  logic [1:0]           op_size,
    input  logic                 sub_en,
    input  logic                 ext_en,
    input  logic                 ext_in,
    output logic [DATA_W-1:0]    sum_q,
    output logic [NUM_BYTES-1:0] lane_carry_q,
    output logic                 carry_flag_q
);
    add_ctl_t             ctl;
    logic [CHAIN_W-1:0]   wide_a, wide_b, wide_s;
    logic                 chain_cin, chain_cout;
    logic [DATA_W-1:0]    sum_d;
    logic [NUM_BYTES-1:0] lane_d;
    logic                 flag_d;

    assign ctl.mode   = lane_mode_e'(lane_mode);
    assign ctl.sub    = sub_en;
    assign ctl.ext_en = ext_en;
    assign ctl.ext_in = ext_in;

    guard_encoder #(.LANE_W(LANE_W), .NUM_BYTES(NUM_BYTES)) u_enc (
        .a(op_a), .b(op_b), .ctl(ctl),
        .wide_a(wide_a), .wide_b(wide_b), .cin(chain_cin)
    );

    carry_chain #(.W(CHAIN_W)) u_chain (
        .x(wide_a), .y(wide_b), .cin(chain_cin),
        .s(wide_s), .cout(chain_cout)
    );

    result_extract #(.LANE_W(LANE_W), .NUM_BYTES(NUM_BYTES)) u_ext (
        .wide_a(wide_a), .wide_b(wide_b), .wide_s(wide_s), .cout(chain_cout),
        .ctl(ctl), .size(op_size_e'(op_size)),
        .sum(sum_d), .lane_c(lane_d), .flag(flag_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sum_q        <= '0;
            lane_carry_q <= '0;
            carry_flag_q <= 1'b0;
        end else begin
            sum_q        <= sum_d;
            lane_carry_q <= lane_d;
            carry_flag_q <= flag_d;
        end
    end
endmodule

// File: rtl/simd_guard_adder_chk.sv
module simd_guard_adder_chk #(
    parameter int LANE_W    = 8,
    parameter int NUM_BYTES = 8,
    localparam int DATA_W   = LANE_W * NUM_BYTES
) (
    input logic                 clk,
    input logic                 rst,
    input logic [DATA_W-1:0]    op_a,
    input logic [DATA_W-1:0]    op_b,
    input logic [1:0]           lane_mode,
    input logic [1:0]           op_size,
    input logic                 sub_en,
    input logic                 ext_en,
    input logic                 ext_in,
    input logic [DATA_W-1:0]    sum_q,
    input logic [NUM_BYTES-1:0] lane_carry_q,
    input logic                 carry_flag_q
);
    logic                 armed;
    logic                 plain_full, plain_byte, sub_full, long_add;
    logic [32:0]          low_sum;
    logic [NUM_BYTES-1:0] top_mask;

    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
    end

    assign plain_full = (lane_mode == 2'b00) && !sub_en && !ext_en;
    assign plain_byte = (lane_mode == 2'b11) && !sub_en && !ext_en;
    assign sub_full   = (lane_mode == 2'b00) && sub_en;
    assign long_add   = plain_full && (op_size == 2'b10);
    assign low_sum    = {1'b0, op_a[31:0]} + {1'b0, op_b[31:0]};

    always_comb begin
        top_mask = '0;
        for (int j = 0; j < NUM_BYTES; j++) begin
            if ((((j + 1) % (NUM_BYTES >> lane_mode))) == 0) top_mask[j] = 1'b1;
        end
    end

    AST_FULL_SUM: assert property (@(posedge clk) disable iff (rst || !armed)
        $past(plain_full) |-> sum_q == $past(op_a) + $past(op_b)); // R2

    AST_BYTE_LANE_ISOLATED: assert property (@(posedge clk) disable iff (rst || !armed)
        $past(plain_byte) |-> sum_q[LANE_W-1:0] == $past(op_a[LANE_W-1:0]) + $past(op_b[LANE_W-1:0])); // R3

    AST_LANE_CARRY_UNUSED_ZERO: assert property (@(posedge clk) disable iff (rst || !armed)
        (lane_carry_q & ~$past(top_mask)) == '0); // R4

    AST_LONG_FLAG: assert property (@(posedge clk) disable iff (rst || !armed)
        $past(long_add) |-> carry_flag_q == $past(low_sum[32])); // R5

    AST_FULL_DIFF: assert property (@(posedge clk) disable iff (rst || !armed)
        $past(sub_full) |-> sum_q == $past(op_a) - $past(op_b)); // R6
endmodule

bind simd_guard_adder simd_guard_adder_chk #(.LANE_W(LANE_W), .NUM_BYTES(NUM_BYTES)) u_chk (
    .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .lane_mode(lane_mode),
    .op_size(op_size), .sub_en(sub_en), .ext_en(ext_en), .ext_in(ext_in),
    .sum_q(sum_q), .lane_carry_q(lane_carry_q), .carry_flag_q(carry_flag_q)
);

// File: tb/simd_guard_adder_tb.sv
module simd_guard_adder_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] op_a = '0, op_b = '0;
    logic [1:0]  lane_mode = '0, op_size = '0;
    logic        sub_en = 1'b0, ext_en = 1'b0, ext_in = 1'b0;
    logic [63:0] sum_q;
    logic [7:0]  lane_carry_q;
    logic        carry_flag_q;
    int          checks = 0;
    int          errors = 0;
    logic [63:0] seed = 64'h9E37_79B9_7F4A_7C15;

    always #10 clk = ~clk;

    simd_guard_adder u_dut (
        .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .lane_mode(lane_mode),
        .op_size(op_size), .sub_en(sub_en), .ext_en(ext_en), .ext_in(ext_in),
        .sum_q(sum_q), .lane_carry_q(lane_carry_q), .carry_flag_q(carry_flag_q)
    );

    task automatic check(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Model built from separate narrow additions
    task automatic ref_calc(input logic [63:0] a, input logic [63:0] b, input logic [1:0] m,
                            input logic [1:0] sz, input logic s, input logic xe, input logic xi,
                            output logic [63:0] rs, output logic [7:0] rc, output logic rf);
        int span, w, nl, fw;
        logic cin;
        logic [64:0] mask, bb, t;
        span = 8 >> m;
        w    = span * 8;
        nl   = 8 / span;
        cin  = s | (xe & xi);
        bb   = {1'b0, (s ? ~b : b)};
        mask = (65'd1 << w) - 65'd1;
        rs = '0;
        rc = '0;
        for (int l = 0; l < nl; l++) begin
            logic [64:0] al, bl, tl;
            al = ({1'b0, a} >> (l * w)) & mask;
            bl = (bb >> (l * w)) & mask;
            tl = al + bl + {64'd0, cin};
            rs = rs | 64'((tl & mask) << (l * w));
            rc[(l + 1) * span - 1] = tl[w] ^ s;
        end
        fw   = 8 << sz;
        mask = (65'd1 << fw) - 65'd1;
        t    = ({1'b0, a} & mask) + (bb & mask) + {64'd0, cin};
        rf   = t[fw] ^ s;
    endtask

    task automatic apply(input logic [63:0] a, input logic [63:0] b, input logic [1:0] m,
                         input logic [1:0] sz, input logic s, input logic xe, input logic xi,
                         input string req);
        logic [63:0] es;
        logic [7:0]  ec;
        logic        ef;
        ref_calc(a, b, m, sz, s, xe, xi, es, ec, ef);
        @(negedge clk);
        op_a = a; op_b = b; lane_mode = m; op_size = sz;
        sub_en = s; ext_en = xe; ext_in = xi;
        @(negedge clk);
        check(sum_q == es, {req, " sum"}, sum_q, es);
        check(lane_carry_q == ec, {req, " R4 lane carry"}, {56'd0, lane_carry_q}, {56'd0, ec});
        if (m == 2'b00)
            check(carry_flag_q == ef, {req, " R5 flag"}, {63'd0, carry_flag_q}, {63'd0, ef});
    endtask

    task automatic t_reset;
        apply(64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 2'b00, 2'b11, 1'b0, 1'b0, 1'b0, "R2 preload");
        @(negedge clk); rst = 1'b1;
        @(negedge clk);
        check(sum_q == '0, "R1 sum", sum_q, 64'd0);
        check(lane_carry_q == '0, "R1 lane carry", {56'd0, lane_carry_q}, 64'd0);
        check(carry_flag_q == 1'b0, "R1 flag", {63'd0, carry_flag_q}, 64'd0);
        rst = 1'b0;
    endtask

    task automatic t_scalar;
        apply(64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321, 2'b00, 2'b11, 1'b0, 1'b0, 1'b0, "R2 full add");
        for (int sz = 0; sz < 4; sz++) begin
            apply(64'h0000_00FF_00FF_FFFF, 64'h1, 2'b00, sz[1:0], 1'b0, 1'b0, 1'b0, "R5 size ripple");
            apply(64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 2'b00, sz[1:0], 1'b0, 1'b0, 1'b0, "R5 all ones");
            apply(64'h0000_0000_8000_8080, 64'h0000_0000_8000_8080, 2'b00, sz[1:0], 1'b0, 1'b0, 1'b0, "R5 edge bits");
        end
    endtask

    task automatic t_lanes;
        for (int m = 0; m < 4; m++) begin
            apply(64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101, m[1:0], 2'b11, 1'b0, 1'b0, 1'b0, "R3 ripple edges");
            apply(64'h80FF_7F00_FFFF_0001, 64'h8001_0100_0001_FFFF, m[1:0], 2'b00, 1'b0, 1'b0, 1'b0, "R3 mixed");
        end
    endtask

    task automatic t_sub;
        for (int m = 0; m < 4; m++) begin
            apply(64'h0001_0000_0100_0005, 64'h0002_0001_0001_0003, m[1:0], 2'b10, 1'b1, 1'b0, 1'b0, "R6 borrow mix");
            apply(64'h0, 64'h1, m[1:0], 2'b00, 1'b1, 1'b0, 1'b0, "R6 zero minus one");
        end
    endtask

    task automatic t_extend;
        for (int m = 0; m < 4; m++) begin
            apply(64'hFFFF_FFFF_FFFF_FFFF, 64'h0, m[1:0], 2'b01, 1'b0, 1'b1, 1'b1, "R7 extend set");
            apply(64'hFFFF_FFFF_FFFF_FFFF, 64'h0, m[1:0], 2'b01, 1'b0, 1'b1, 1'b0, "R7 extend clear");
            apply(64'hFFFF_FFFF_FFFF_FFFF, 64'h0, m[1:0], 2'b01, 1'b0, 1'b0, 1'b1, "R7 ext_in ignored");
        end
    endtask

    task automatic t_priority;
        for (int m = 0; m < 4; m++) begin
            apply(64'h0102_0304_0506_0708, 64'h0807_0605_0403_0201, m[1:0], 2'b00, 1'b1, 1'b1, 1'b0, "R8 sub over extend 0");
            apply(64'h0102_0304_0506_0708, 64'h0807_0605_0403_0201, m[1:0], 2'b00, 1'b1, 1'b1, 1'b1, "R8 sub over extend 1");
        end
    endtask

    task automatic t_random;
        for (int i = 0; i < 48; i++) begin
            logic [63:0] ra, rb;
            seed = seed ^ (seed << 13); seed = seed ^ (seed >> 7); seed = seed ^ (seed << 17);
            ra = seed;
            seed = seed ^ (seed << 13); seed = seed ^ (seed >> 7); seed = seed ^ (seed << 17);
            rb = seed;
            apply(ra, rb, i[1:0], i[3:2], i[4], i[5], rb[0], "R3 R6 R7 random");
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_scalar();
        t_lanes();
        t_sub();
        t_extend();
        t_priority();
        t_random();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=0", 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule